// File: doc/BRIEF.md
# EEPROM Page-Write and Protection Controller

This controller sits between the serial command decoder of a serial EEPROM and its cell array. The decoder hands it single-cycle events: set or clear the write-enable latch, write the status register, open a data write at an address, deliver a data byte, and the rise of chip select that ends a transaction. Data bytes go into an on-chip page buffer. When chip select rises after at least one whole byte, a self-timed programming cycle starts. During that cycle the buffered bytes are sent to the array as write strobes and a busy flag is raised.

Two mechanisms can block a write. Two block-protect bits in the status register fence off part of the array: none of it, the top quarter, the top half, or all of it. A protect-enable bit in the status register turns on the active-low write-protect pin, and when both are active every status write is refused. The length of the programming cycle is a parameter counted in system clocks. A short value can therefore stand in for the real milliseconds in simulation.

Top module: `eeprom_pgwr_ctrl`

## Requirements
- R1: After reset, `status_o` reads 0 (not busy, write enable clear, no block protection, protect enable clear) and no array strobe is issued.
- R2: When not busy, `wren_i` sets the write-enable latch (status bit 1) and `wrdi_i` clears it.
- R3: A data write opened while the write-enable latch is clear is ignored: no programming cycle and no array strobe follow.
- R4: The low log2(PAGE_BYTES) address bits give the starting offset in the page buffer. The offset increments with each byte and wraps inside the same page. A later byte at an offset already written replaces the earlier one, and only offsets that received a byte are written to the array.
- R5: A programming cycle starts only when `cs_rise_i` arrives with at least one whole byte buffered and `partial_i` low. Otherwise the transaction is dropped without a cycle and the write-enable latch keeps its value.
- R6: Once started, `busy_o` and status bit 0 stay high for exactly CYC_CLKS clocks. During that time each buffered byte is strobed once on `arr_we_o`, at address {page, offset}.
- R7: The write-enable latch clears when the programming cycle completes.
- R8: While busy, `wren_i`, `wrdi_i`, `wrsr_i` and new data writes are all ignored. The write-enable latch, the status bits and the array contents stay unchanged.
- R9: Block protect value BP (status bits 3:2) blocks writes to: nothing for 0, the top quarter of the address space for 1, the top half for 2, and everything for 3. The region is chosen from the two top address bits of the start address. A refused write clears the write-enable latch and produces no strobe.
- R10: A status write accepted with the write-enable latch set copies `sr_wdata_i` bits 3:2 into BP and bit 7 into protect enable (status bit 7), then clears the write-enable latch.
- R11: When protect enable is 1 and `wp_n_i` is low, a status write leaves BP and protect enable unchanged and clears the write-enable latch. When protect enable is 0, `wp_n_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_i | input | 1 | Set write-enable latch (pulse) |
| wrdi_i | input | 1 | Clear write-enable latch (pulse) |
| wrsr_i | input | 1 | Status register write (pulse) |
| sr_wdata_i | input | 8 | Status write value; bits 7 and 3:2 are used |
| wr_start_i | input | 1 | Open a data write (pulse) |
| wr_addr_i | input | ADDR_W | Start address of the data write |
| wr_byte_i | input | 1 | One data byte is valid (pulse) |
| wr_data_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | Chip select went high, end of transaction (pulse) |
| partial_i | input | 1 | An incomplete byte was clocked before `cs_rise_i` |
| wp_n_i | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | {protect enable, 000, BP[1:0], write enable, busy} |
| busy_o | output | 1 | Programming cycle in progress |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | ADDR_W | Array byte address |
| arr_wdata_o | output | 8 | Array byte data |

## Verification
The bench targets three error classes.

- **Page wrap.** A page write that starts near the top of a page and runs past its length has to wrap. A design that carried into the page number would corrupt the next page. A design that dropped the overwrite would leave stale bytes in place.
- **Protection.** Every BP value is swept against every quarter of the address space. A mistake in the region decode shows up as strobes into a fenced region or as a missing strobe to an open one.
- **Aborts and busy.** Aborted transactions, status writes under every combination of write-protect pin and protect enable, and commands issued mid-cycle are all exercised. A design that started cycles on partial bytes, let the pin act without protect enable, or accepted commands while busy would show a wrong status byte or extra array writes.

// File: rtl/eeprom_pgwr_pkg.sv
package eeprom_pgwr_pkg;

  typedef enum logic [1:0] {
    PROT_NONE    = 2'd0,
    PROT_QUARTER = 2'd1,
    PROT_HALF    = 2'd2,
    PROT_ALL     = 2'd3
  } prot_e;

  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_WEL  = 1;
  localparam int unsigned ST_BP_LO = 2;
  localparam int unsigned ST_BP_HI = 3;
  localparam int unsigned ST_PEN  = 7;

endpackage

// File: rtl/eeprom_pgwr_guard.sv
module eeprom_pgwr_guard
  import eeprom_pgwr_pkg::*;
(
  input  prot_e      bp_i,
  input  logic       pen_i,
  input  logic       wp_n_i,
  input  logic [1:0] addr_top_i,
  output logic       region_lock_o,
  output logic       sr_lock_o
);

  always_comb begin
    unique case (bp_i)
      PROT_NONE:    region_lock_o = 1'b0;
      PROT_QUARTER: region_lock_o = &addr_top_i;
      PROT_HALF:    region_lock_o = addr_top_i[1];
      default:      region_lock_o = 1'b1;
    endcase
  end

  assign sr_lock_o = pen_i & ~wp_n_i;

endmodule

// File: rtl/eeprom_pgwr_latch.sv
module eeprom_pgwr_latch #(
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [OFF_W-1:0]  base_off_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFF_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_vld_o
);

  logic [DATA_W-1:0]     buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [OFF_W-1:0]      off_q, off_d;
  logic                  off_en;

  always_comb begin
    mask_d = mask_q;
    off_d  = off_q;
    if (clr_i) begin
      mask_d = '0;
      off_d  = base_off_i;
    end else if (wr_i) begin
      mask_d[off_q] = 1'b1;
      off_d         = off_q + 1'b1;
    end
  end

  assign off_en = clr_i | wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      off_q  <= '0;
    end else if (off_en) begin
      mask_q <= mask_d;
      off_q  <= off_d;
    end
  end

  generate
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
      logic ent_en;
      assign ent_en = wr_i & ~clr_i & (off_q == OFF_W'(g));
      always_ff @(posedge clk) begin
        if (ent_en) buf_q[g] <= wr_data_i;
      end
    end
  endgenerate

  assign rd_data_o = buf_q[rd_idx_i];
  assign rd_vld_o  = mask_q[rd_idx_i];
  assign any_vld_o = |mask_q;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !any_vld_o) else $error("buffer not emptied on new write"); // R4

endmodule

// File: rtl/eeprom_pgwr_timer.sv
module eeprom_pgwr_timer #(
  parameter int unsigned CYC_CLKS = 200000,
  localparam int unsigned CNT_W   = $clog2(CYC_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_CLKS - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tmr_en;

  assign done_o = busy_q & (cnt_q == LAST);
  assign tmr_en = start_i | busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (done_o) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tmr_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

  AST_CYCLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST) |=> !busy_q) else $error("cycle overran"); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start_i) else $error("start while busy"); // R8

endmodule

// File: rtl/eeprom_pgwr_ctrl.sv
module eeprom_pgwr_ctrl
  import eeprom_pgwr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned CYC_CLKS   = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        sr_wdata_i,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_byte_i,
  input  logic [7:0]        wr_data_i,
  input  logic              cs_rise_i,
  input  logic              partial_i,
  input  logic              wp_n_i,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [7:0]        arr_wdata_o
);

  localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
  localparam int unsigned PG_W   = ADDR_W - OFF_W;
  localparam int unsigned EFF_CLKS = (CYC_CLKS > PAGE_BYTES) ? CYC_CLKS : PAGE_BYTES + 1;
  localparam int unsigned CNT_W  = $clog2(EFF_CLKS);

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic            wel_q, wel_d;
  logic            sess_q, sess_d;
  prot_e           bp_q, bp_d;
  logic            pen_q, pen_d;
  logic [PG_W-1:0] page_q;
  logic            ctl_en, page_en;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             cyc_done;
  logic             region_lock, sr_lock;
  logic             start_try, sr_try, sess_open, commit;
  logic [7:0]       buf_rd;
  logic             buf_vld, buf_any;
  logic             unused_sr_bits;

  assign unused_sr_bits = ^{sr_wdata_i[6:4], sr_wdata_i[1:0]};

  eeprom_pgwr_guard u_guard (
    .bp_i          (bp_q),
    .pen_i         (pen_q),
    .wp_n_i        (wp_n_i),
    .addr_top_i    (wr_addr_i[ADDR_W-1 -: 2]),
    .region_lock_o (region_lock),
    .sr_lock_o     (sr_lock)
  );

  assign start_try = ~busy & wr_start_i & wel_q & ~sess_q;
  assign sess_open = start_try & ~region_lock;
  assign sr_try    = ~busy & wrsr_i & wel_q & ~sess_q;
  assign commit    = cs_rise_i & sess_q & wel_q & ~partial_i & buf_any;

  eeprom_pgwr_latch #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (8)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (sess_open),
    .base_off_i (wr_addr_i[OFF_W-1:0]),
    .wr_i       (wr_byte_i & sess_q),
    .wr_data_i  (wr_data_i),
    .rd_idx_i   (cnt[OFF_W-1:0]),
    .rd_data_o  (buf_rd),
    .rd_vld_o   (buf_vld),
    .any_vld_o  (buf_any)
  );

  eeprom_pgwr_timer #(
    .CYC_CLKS (EFF_CLKS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (commit),
    .busy_o  (busy),
    .cnt_o   (cnt),
    .done_o  (cyc_done)
  );

  always_comb begin
    wel_d  = wel_q;
    sess_d = sess_q;
    bp_d   = bp_q;
    pen_d  = pen_q;
    if (cyc_done) begin
      wel_d = 1'b0;
    end else if (!busy) begin
      if (wren_i) wel_d = 1'b1;
      if (wrdi_i) wel_d = 1'b0;
      if (sr_try) begin
        wel_d = 1'b0;
        if (!sr_lock) begin
          bp_d  = prot_e'(sr_wdata_i[ST_BP_HI:ST_BP_LO]);
          pen_d = sr_wdata_i[ST_PEN];
        end
      end
      if (start_try) begin
        if (region_lock) wel_d = 1'b0;
        else             sess_d = 1'b1;
      end
      if (cs_rise_i) sess_d = 1'b0;
    end
  end

  assign ctl_en  = cyc_done | ~busy;
  assign page_en = sess_open;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wel_q  <= 1'b0;
      sess_q <= 1'b0;
      bp_q   <= PROT_NONE;
      pen_q  <= 1'b0;
    end else if (ctl_en) begin
      wel_q  <= wel_d;
      sess_q <= sess_d;
      bp_q   <= bp_d;
      pen_q  <= pen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  page_q <= '0;
    else if (page_en) page_q <= wr_addr_i[ADDR_W-1:OFF_W];
  end

  assign busy_o      = busy;
  assign arr_we_o    = busy & (cnt < CNT_W'(PAGE_BYTES)) & buf_vld;
  assign arr_addr_o  = {page_q, cnt[OFF_W-1:0]};
  assign arr_wdata_o = buf_rd;

  always_comb begin
    status_o                   = '0;
    status_o[ST_BUSY]          = busy;
    status_o[ST_WEL]           = wel_q;
    status_o[ST_BP_HI:ST_BP_LO] = bp_q;
    status_o[ST_PEN]           = pen_q;
  end

  AST_BUSY_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> wel_q) else $error("wel lost mid-cycle"); // R6
  AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> !wel_q) else $error("wel kept after cycle"); // R7
  AST_SR_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wrsr_i && pen_q && !wp_n_i) |=> ($stable(bp_q) && $stable(pen_q))) else $error("locked status changed"); // R11
  AST_PROT_REJECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_start_i && !busy && !sess_q && region_lock) |=> !sess_q) else $error("protected write opened"); // R9
  AST_NO_WEL_NO_SESSION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_start_i && !wel_q && !sess_q) |=> !sess_q) else $error("write without wel"); // R3
  AST_BUSY_NO_SESSION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> !sess_q) else $error("session during cycle"); // R8
  AST_BUSY_SR_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && wrsr_i) |=> $stable(bp_q)) else $error("status written while busy"); // R8

endmodule

// File: tb/eeprom_pgwr_ctrl_bench.sv
module eeprom_pgwr_ctrl_bench;

  localparam int AW = 8;
  localparam int PB = 8;
  localparam int TC = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wren_i = 0, wrdi_i = 0, wrsr_i = 0, wr_start_i = 0, wr_byte_i = 0;
  logic cs_rise_i = 0, partial_i = 0, wp_n_i = 1;
  logic [7:0] sr_wdata_i = '0, wr_data_i = '0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [7:0] status_o, arr_wdata_o;
  logic busy_o, arr_we_o;
  logic [AW-1:0] arr_addr_o;

  always #2 clk = ~clk;

  eeprom_pgwr_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .CYC_CLKS(TC)) u_eeprom_pgwr_ctrl (
    .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_i(wrsr_i),
    .sr_wdata_i(sr_wdata_i), .wr_start_i(wr_start_i), .wr_addr_i(wr_addr_i),
    .wr_byte_i(wr_byte_i), .wr_data_i(wr_data_i), .cs_rise_i(cs_rise_i),
    .partial_i(partial_i), .wp_n_i(wp_n_i), .status_o(status_o), .busy_o(busy_o),
    .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_wdata_o(arr_wdata_o));

  int nchk = 0, nfail = 0, strobes = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] cap [DEPTH];
  logic [7:0] mdl [DEPTH];
  bit wel_m = 0, pen_m = 0;
  int bp_m = 0;

  always @(negedge clk) begin
    if (arr_we_o) begin
      cap[arr_addr_o] = arr_wdata_o;
      strobes++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog: got %0d cycles expected < 100000", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string req);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mem_chk(input string req);
    int bad = 0;
    for (int a = 0; a < DEPTH; a++) if (cap[a] !== mdl[a]) bad++;
    chk(bad, 0, req);
  endtask

  function automatic int exp_status();
    return (pen_m << 7) | (bp_m << 2) | (wel_m << 1);
  endfunction

  function automatic bit locked(input int addr);
    int top = addr >> (AW - 2);
    case (bp_m)
      0: return 0;
      1: return top == 3;
      2: return top >= 2;
      default: return 1;
    endcase
  endfunction

  task automatic p_wren(); @(negedge clk) wren_i = 1; @(negedge clk) wren_i = 0; endtask
  task automatic p_wrdi(); @(negedge clk) wrdi_i = 1; @(negedge clk) wrdi_i = 0; endtask
  task automatic p_wrsr(input int d);
    @(negedge clk) begin wrsr_i = 1; sr_wdata_i = 8'(d); end
    @(negedge clk) wrsr_i = 0;
  endtask
  task automatic p_start(input int a);
    @(negedge clk) begin wr_start_i = 1; wr_addr_i = AW'(a); end
    @(negedge clk) wr_start_i = 0;
  endtask
  task automatic p_byte(input int d);
    @(negedge clk) begin wr_byte_i = 1; wr_data_i = 8'(d); end
    @(negedge clk) wr_byte_i = 0;
  endtask
  task automatic p_cs(input bit part);
    @(negedge clk) begin cs_rise_i = 1; partial_i = part; end
    @(negedge clk) begin cs_rise_i = 0; partial_i = 0; end
  endtask

  task automatic wait_idle(output int len);
    len = 0;
    while (busy_o && len < 1000) begin len++; @(negedge clk); end
  endtask

  // full transaction with model update; returns expected strobe count
  task automatic txn(input int addr, input int n, input int seed, input bit part, output int exp_st);
    bit acc, rej;
    bit [PB-1:0] m = '0;
    logic [7:0] pg [PB];
    int off = addr % PB;
    int base = addr - off;
    acc = wel_m && !locked(addr);
    rej = wel_m && locked(addr);
    exp_st = 0;
    p_start(addr);
    for (int i = 0; i < n; i++) begin
      int d = (addr * 7 + i * 13 + seed) & 255;
      p_byte(d);
      pg[off] = 8'(d); m[off] = 1'b1; off = (off + 1) % PB;
    end
    p_cs(part);
    if (rej) wel_m = 0;
    if (acc && n > 0 && !part) begin
      for (int o = 0; o < PB; o++) if (m[o]) begin mdl[base + o] = pg[o]; exp_st++; end
      wel_m = 0;
    end
  endtask

  int len, est, s0;

  initial begin
    for (int a = 0; a < DEPTH; a++) begin cap[a] = 8'h00; mdl[a] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    chk(status_o, 0, "R1 status after reset");
    chk(strobes, 0, "R1 no strobes after reset");

    // R3: write without write enable
    s0 = strobes;
    txn(8'h10, 3, 1, 0, est);
    wait_idle(len);
    chk(len, 0, "R3 no cycle without wel");
    chk(strobes - s0, 0, "R3 no strobes without wel");

    // R2
    p_wren(); wel_m = 1;
    chk(status_o, exp_status(), "R2 wren sets wel");
    p_wrdi(); wel_m = 0;
    chk(status_o, exp_status(), "R2 wrdi clears wel");

    // single byte, cycle length R6, wel clear R7
    p_wren(); wel_m = 1;
    s0 = strobes;
    txn(8'h21, 1, 5, 0, est);
    wait_idle(len);
    chk(len, TC, "R6 busy length");
    chk(strobes - s0, est, "R6 one strobe per byte");
    chk(status_o, exp_status(), "R7 wel cleared at end");
    mem_chk("R6 byte placed");

    // page wrap with overwrite R4
    p_wren(); wel_m = 1;
    s0 = strobes;
    txn(8'h45, PB + 2, 9, 0, est);
    wait_idle(len);
    chk(strobes - s0, PB, "R4 wrap strobes");
    mem_chk("R4 wrap and overwrite");

    // aborts R5
    p_wren(); wel_m = 1;
    s0 = strobes;
    txn(8'h30, 2, 3, 1, est);
    wait_idle(len);
    chk(len, 0, "R5 partial byte no cycle");
    chk(status_o, exp_status(), "R5 wel kept after partial");
    txn(8'h30, 0, 3, 0, est);
    wait_idle(len);
    chk(len, 0, "R5 zero bytes no cycle");
    chk(strobes - s0, 0, "R5 no strobes on abort");
    chk(status_o, exp_status(), "R5 wel kept after empty");

    // commands while busy R8
    s0 = strobes;
    txn(8'h12, 4, 11, 0, est);
    p_wrdi();
    chk(status_o[1], 1, "R8 wrdi ignored while busy");
    p_wrsr(8'h8C);
    p_start(8'h52); p_byte(8'hAA); p_cs(0);
    wait_idle(len);
    chk(status_o, exp_status(), "R8 status untouched by busy commands");
    chk(strobes - s0, est, "R8 no second cycle");
    mem_chk("R8 array only first write");

    // protection sweep R9 and status write R10
    for (int b = 0; b < 4; b++) begin
      p_wren();
      p_wrsr(b << 2);
      bp_m = b; wel_m = 0;
      chk(status_o, exp_status(), "R10 bp written");
      for (int q = 0; q < 4; q++) begin
        int a = q * (DEPTH / 4) + ((b * 5 + q * 3) % (DEPTH / 4));
        p_wren(); wel_m = 1;
        s0 = strobes;
        txn(a, 3, b * 4 + q, 0, est);
        wait_idle(len);
        chk(strobes - s0, est, "R9 strobes for region");
        chk(status_o, exp_status(), "R9 wel after write or reject");
      end
    end
    mem_chk("R9 array after sweep");

    // write-protect pin R11
    p_wren(); p_wrsr(8'h80); pen_m = 1; bp_m = 0; wel_m = 0;
    chk(status_o, exp_status(), "R10 pen written");
    wp_n_i = 0;
    p_wren(); p_wrsr(8'h84);
    chk(status_o, exp_status(), "R11 locked status write rejected");
    wp_n_i = 1;
    p_wren(); p_wrsr(8'h00); pen_m = 0;
    chk(status_o, exp_status(), "R11 unlocked with pin high");
    wp_n_i = 0;
    p_wren(); p_wrsr(8'h04); bp_m = 1;
    chk(status_o, exp_status(), "R11 pin ignored when pen clear");
    wp_n_i = 1;

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule